// File: doc/BRIEF.md
# Hash Round-Function Pool

This unit is the shared logic-function stage of a hash coprocessor that handles MD5, SHA-1, SHA-256 and SHA-512 (the latter also serving SHA-384). It does not hard-wire one round-function circuit per algorithm. Instead it keeps a single pool of boolean equations (choose, parity, majority and two MD5-only selects) and two banks of three-way rotate-XOR networks. A per-round selector picks from that pool. The surrounding datapath supplies three working words and a step strobe for each round. It takes back the selected function value, a secondary value, and the two Sigma rotate-XOR results.

The algorithm is chosen only by a configuration write. That write also returns the internal round counter to round 0. Each step strobe makes the unit evaluate the equation that belongs to the current round, register the results, and advance the counter. The counter wraps back to 0 after the final round of the active algorithm. SHA-512 mode works on full 64-bit words. The other three modes work on the low 32 bits and return zeros in the upper half.

Top module: `hash_logic_pool`

## Requirements
- R1: After reset, `res_vld` is 0 and every data output is 0. The mode is MD5 (code 0) and the round counter is 0, so a step issued without any configuration write returns the MD5 round-0 function.
- R2: A configuration write loads `cfg_mode` and clears the round counter to 0. The mode codes are 0 for MD5, 1 for SHA-1, 2 for SHA-256 and 3 for SHA-512. If a step arrives in the same cycle as a configuration write, the step is ignored: no result is produced and the counter does not advance.
- R3: A step in cycle n raises `res_vld` for exactly cycle n+1, and the results appear in that cycle. Between steps, all data outputs hold their last value.
- R4: In MD5 mode, `fn_out` follows the round number. Rounds 0–15 give choose (x&y)^(~x&z). Rounds 16–31 give the z-gated select (x&z)|(y&~z). Rounds 32–47 give parity x^y^z. Rounds 48–63 give y^(x|~z). After round 63 the counter wraps to 0.
- R5: In SHA-1 mode, `fn_out` follows the round number. Rounds 0–19 give choose, 20–39 give parity, 40–59 give majority (x&y)^(x&z)^(y&z), and 60–79 give parity. After round 79 the counter wraps to 0.
- R6: In both SHA-2 modes, every round gives `fn_out` = choose and `aux_out` = majority. The counter wraps after round 63 for SHA-256 and after round 79 for SHA-512.
- R7: In SHA-256 mode, `sig0_out` = rotr2^rotr13^rotr22 of x and `sig1_out` = rotr6^rotr11^rotr25 of x, both computed on 32-bit words.
- R8: In SHA-512 mode, `sig0_out` = rotr28^rotr34^rotr39 of x and `sig1_out` = rotr14^rotr18^rotr41 of x, both computed on 64-bit words.
- R9: In MD5, SHA-1 and SHA-256 modes, only bits 31:0 of the inputs are used and bits 63:32 of every data output are 0. In SHA-512 mode all 64 bits are used.
- R10: In MD5 and SHA-1 modes, `aux_out`, `sig0_out` and `sig1_out` are 0 on every result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Algorithm code loaded on a configuration write |
| step | input | 1 | Evaluate the current round and advance the counter |
| x_in | input | 64 | Working word x |
| y_in | input | 64 | Working word y |
| z_in | input | 64 | Working word z |
| res_vld | output | 1 | Results of the previous step are present |
| fn_out | output | 64 | Selected round function |
| aux_out | output | 64 | Majority value in SHA-2 modes, 0 otherwise |
| sig0_out | output | 64 | First Sigma rotate-XOR of x |
| sig1_out | output | 64 | Second Sigma rotate-XOR of x |

## Verification
Every result comes from a single register stage. It is therefore due exactly one cycle after its strobe, and a configuration write changes mode and round one cycle after it is presented. The driver drives the inputs on falling edges and pushes an expected record, computed from its own mode and round model, at the moment it raises the strobe. The monitor samples on the following falling edge. By then exactly one rising edge has passed, so the record at the head of the queue must match the outputs. In cycles with no result the monitor instead checks that the outputs still equal the last expected value. A spurious or missing valid therefore shows up as a queue mismatch.

// File: rtl/hlp_pkg.sv
package hlp_pkg;

   typedef enum logic [1:0] {
      HM_MD5    = 2'd0,
      HM_SHA1   = 2'd1,
      HM_SHA256 = 2'd2,
      HM_SHA512 = 2'd3
   } hmode_e;

   typedef enum logic [2:0] {
      FS_CHOOSE = 3'd0,
      FS_PARITY = 3'd1,
      FS_MAJ    = 3'd2,
      FS_ZSEL   = 3'd3,
      FS_YXOR   = 3'd4
   } fsel_e;

endpackage

// File: rtl/hlp_round_ctr.sv
module hlp_round_ctr
   import hlp_pkg::*;
#(
   parameter int unsigned RW     = 7,
   parameter int unsigned MD5_N  = 64,
   parameter int unsigned SHA1_N = 80,
   parameter int unsigned S256_N = 64,
   parameter int unsigned S512_N = 80
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_wr,
   input  logic [1:0]    cfg_mode,
   input  logic          step,
   output hmode_e        mode_q,
   output logic [RW-1:0] rnd_q,
   output logic          step_go
);

   localparam logic [RW-1:0] LAST_MD5  = RW'(MD5_N - 1);
   localparam logic [RW-1:0] LAST_SHA1 = RW'(SHA1_N - 1);
   localparam logic [RW-1:0] LAST_256  = RW'(S256_N - 1);
   localparam logic [RW-1:0] LAST_512  = RW'(S512_N - 1);

   if (MD5_N > (1 << RW) || SHA1_N > (1 << RW) ||
       S256_N > (1 << RW) || S512_N > (1 << RW)) begin : g_rw_chk
      $error("round counter width too small for the round counts");
   end

   logic [RW-1:0] last_rnd;

   assign step_go = step & ~cfg_wr;

   always_comb begin
      unique case (mode_q)
         HM_MD5:    last_rnd = LAST_MD5;
         HM_SHA1:   last_rnd = LAST_SHA1;
         HM_SHA256: last_rnd = LAST_256;
         default:   last_rnd = LAST_512;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= HM_MD5;
         rnd_q  <= '0;
      end else if (cfg_wr) begin
         mode_q <= hmode_e'(cfg_mode);
         rnd_q  <= '0;
      end else if (step) begin
         rnd_q <= (rnd_q == last_rnd) ? '0 : rnd_q + 1'b1;
      end
   end

endmodule

// File: rtl/hlp_fn_map.sv
module hlp_fn_map
   import hlp_pkg::*;
#(
   parameter int unsigned RW       = 7,
   parameter int unsigned MD5_SEG  = 16,
   parameter int unsigned SHA1_SEG = 20
) (
   input  hmode_e        mode,
   input  logic [RW-1:0] rnd,
   output fsel_e         fsel
);

   localparam logic [RW-1:0] M1 = RW'(MD5_SEG);
   localparam logic [RW-1:0] M2 = RW'(2 * MD5_SEG);
   localparam logic [RW-1:0] M3 = RW'(3 * MD5_SEG);
   localparam logic [RW-1:0] S1 = RW'(SHA1_SEG);
   localparam logic [RW-1:0] S2 = RW'(2 * SHA1_SEG);
   localparam logic [RW-1:0] S3 = RW'(3 * SHA1_SEG);

   always_comb begin
      fsel = FS_CHOOSE;
      unique case (mode)
         HM_MD5: begin
            if (rnd < M1)      fsel = FS_CHOOSE;
            else if (rnd < M2) fsel = FS_ZSEL;
            else if (rnd < M3) fsel = FS_PARITY;
            else               fsel = FS_YXOR;
         end
         HM_SHA1: begin
            if (rnd < S1)      fsel = FS_CHOOSE;
            else if (rnd < S2) fsel = FS_PARITY;
            else if (rnd < S3) fsel = FS_MAJ;
            else               fsel = FS_PARITY;
         end
         default: fsel = FS_CHOOSE;
      endcase
   end

endmodule

// File: rtl/hlp_bool_pool.sv
module hlp_bool_pool #(
   parameter int unsigned W = 64
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic [W-1:0] z,
   output logic [W-1:0] f_ch,
   output logic [W-1:0] f_par,
   output logic [W-1:0] f_maj,
   output logic [W-1:0] f_zsel,
   output logic [W-1:0] f_yxor
);

   assign f_ch   = (x & y) ^ (~x & z);
   assign f_par  = x ^ y ^ z;
   assign f_maj  = (x & y) ^ (x & z) ^ (y & z);
   assign f_zsel = (x & z) | (y & ~z);
   assign f_yxor = y ^ (x | ~z);

endmodule

// File: rtl/hlp_rotxor.sv
module hlp_rotxor #(
   parameter int unsigned W  = 32,
   parameter int unsigned RA = 2,
   parameter int unsigned RB = 13,
   parameter int unsigned RC = 22
) (
   input  logic [W-1:0] v,
   output logic [W-1:0] r
);

   if (RA == 0 || RA >= W || RB == 0 || RB >= W || RC == 0 || RC >= W) begin : g_amt_chk
      $error("rotation amount out of range for word width");
   end

   function automatic logic [W-1:0] rotr(input logic [W-1:0] a, input int unsigned n);
      return (a >> n) | (a << (W - n));
   endfunction

   assign r = rotr(v, RA) ^ rotr(v, RB) ^ rotr(v, RC);

endmodule

// File: rtl/hash_logic_pool.sv
module hash_logic_pool
   import hlp_pkg::*;
#(
   parameter int unsigned DW       = 64,
   parameter int unsigned RW       = 7,
   parameter int unsigned MD5_N    = 64,
   parameter int unsigned SHA1_N   = 80,
   parameter int unsigned S256_N   = 64,
   parameter int unsigned S512_N   = 80,
   parameter int unsigned ROT_N [6] = '{2, 13, 22, 6, 11, 25},
   parameter int unsigned ROT_W [6] = '{28, 34, 39, 14, 18, 41}
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_wr,
   input  logic [1:0]    cfg_mode,
   input  logic          step,
   input  logic [DW-1:0] x_in,
   input  logic [DW-1:0] y_in,
   input  logic [DW-1:0] z_in,
   output logic          res_vld,
   output logic [DW-1:0] fn_out,
   output logic [DW-1:0] aux_out,
   output logic [DW-1:0] sig0_out,
   output logic [DW-1:0] sig1_out
);

   localparam int unsigned HW = DW / 2;

   if (DW % 2 != 0 || HW < 32) begin : g_dw_chk
      $error("word width must be even and hold two 32-bit halves");
   end

   hmode_e        mode_q;
   logic [RW-1:0] rnd_q;
   logic          step_go;
   fsel_e         fsel;
   logic          wide;
   logic [DW-1:0] mask;
   logic [DW-1:0] xm, ym, zm;
   logic [DW-1:0] f_ch, f_par, f_maj, f_zsel, f_yxor;
   logic [HW-1:0] sn [2];
   logic [DW-1:0] sw [2];
   logic [DW-1:0] fn_nx, aux_nx, s0_nx, s1_nx;
   logic          is_sha2;

   hlp_round_ctr #(
      .RW(RW), .MD5_N(MD5_N), .SHA1_N(SHA1_N), .S256_N(S256_N), .S512_N(S512_N)
   ) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_wr  (cfg_wr),
      .cfg_mode(cfg_mode),
      .step    (step),
      .mode_q  (mode_q),
      .rnd_q   (rnd_q),
      .step_go (step_go)
   );

   hlp_fn_map #(
      .RW(RW), .MD5_SEG(MD5_N / 4), .SHA1_SEG(SHA1_N / 4)
   ) u_map (
      .mode(mode_q),
      .rnd (rnd_q),
      .fsel(fsel)
   );

   assign wide    = (mode_q == HM_SHA512);
   assign is_sha2 = (mode_q == HM_SHA256) || (mode_q == HM_SHA512);
   assign mask    = wide ? {DW{1'b1}} : {{(DW-HW){1'b0}}, {HW{1'b1}}};
   assign xm      = x_in & mask;
   assign ym      = y_in & mask;
   assign zm      = z_in & mask;

   hlp_bool_pool #(.W(DW)) u_pool (
      .x     (xm),
      .y     (ym),
      .z     (zm),
      .f_ch  (f_ch),
      .f_par (f_par),
      .f_maj (f_maj),
      .f_zsel(f_zsel),
      .f_yxor(f_yxor)
   );

   for (genvar g = 0; g < 2; g++) begin : g_sigma
      hlp_rotxor #(
         .W(HW), .RA(ROT_N[3*g]), .RB(ROT_N[3*g+1]), .RC(ROT_N[3*g+2])
      ) u_narrow (
         .v(x_in[HW-1:0]),
         .r(sn[g])
      );
      hlp_rotxor #(
         .W(DW), .RA(ROT_W[3*g]), .RB(ROT_W[3*g+1]), .RC(ROT_W[3*g+2])
      ) u_wide (
         .v(x_in),
         .r(sw[g])
      );
   end

   always_comb begin
      unique case (fsel)
         FS_PARITY: fn_nx = f_par;
         FS_MAJ:    fn_nx = f_maj;
         FS_ZSEL:   fn_nx = f_zsel;
         FS_YXOR:   fn_nx = f_yxor;
         default:   fn_nx = f_ch;
      endcase
      fn_nx  = fn_nx & mask;
      aux_nx = is_sha2 ? (f_maj & mask) : '0;
      if (!is_sha2) begin
         s0_nx = '0;
         s1_nx = '0;
      end else if (wide) begin
         s0_nx = sw[0];
         s1_nx = sw[1];
      end else begin
         s0_nx = {{(DW-HW){1'b0}}, sn[0]};
         s1_nx = {{(DW-HW){1'b0}}, sn[1]};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_vld  <= 1'b0;
         fn_out   <= '0;
         aux_out  <= '0;
         sig0_out <= '0;
         sig1_out <= '0;
      end else begin
         res_vld <= step_go;
         if (step_go) begin
            fn_out   <= fn_nx;
            aux_out  <= aux_nx;
            sig0_out <= s0_nx;
            sig1_out <= s1_nx;
         end
      end
   end

endmodule

// File: rtl/hlp_chk.sv
module hlp_chk
   import hlp_pkg::*;
#(
   parameter int unsigned DW     = 64,
   parameter int unsigned RW     = 7,
   parameter int unsigned MAX_N  = 80
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cfg_wr,
   input logic          step,
   input logic          res_vld,
   input hmode_e        mode_q,
   input logic [RW-1:0] rnd_q,
   input logic [DW-1:0] fn_out,
   input logic [DW-1:0] aux_out,
   input logic [DW-1:0] sig0_out,
   input logic [DW-1:0] sig1_out
);

   localparam int unsigned HW = DW / 2;

   // R3
   vld_after_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !cfg_wr) |=> res_vld);

   // R3
   no_spurious_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(step && !cfg_wr) |=> !res_vld);

   // R3
   hold_between_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(step && !cfg_wr) |=> ($stable(fn_out) && $stable(aux_out) &&
                              $stable(sig0_out) && $stable(sig1_out)));

   // R2
   cfg_clears_round_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> (rnd_q == '0));

   // R2
   mode_only_by_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_wr |=> $stable(mode_q));

   // R6
   round_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rnd_q < RW'(MAX_N));

   // R9
   narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_vld && mode_q != HM_SHA512) |->
         (fn_out[DW-1:HW] == '0 && aux_out[DW-1:HW] == '0 &&
          sig0_out[DW-1:HW] == '0 && sig1_out[DW-1:HW] == '0));

   // R10
   non_sha2_side_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_vld && (mode_q == HM_MD5 || mode_q == HM_SHA1)) |->
         (aux_out == '0 && sig0_out == '0 && sig1_out == '0));

endmodule

bind hash_logic_pool hlp_chk #(.DW(DW), .RW(RW), .MAX_N(SHA1_N > S512_N ? SHA1_N : S512_N)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cfg_wr  (cfg_wr),
   .step    (step),
   .res_vld (res_vld),
   .mode_q  (mode_q),
   .rnd_q   (rnd_q),
   .fn_out  (fn_out),
   .aux_out (aux_out),
   .sig0_out(sig0_out),
   .sig1_out(sig1_out)
);

// File: tb/hash_logic_pool_bench.sv
module hash_logic_pool_bench;

   localparam int CLK_P = 10;

   typedef struct {
      logic [63:0] fn;
      logic [63:0] aux;
      logic [63:0] s0;
      logic [63:0] s1;
      string       rq;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [1:0]  cfg_mode = 2'd0;
   logic        step = 1'b0;
   logic [63:0] x_in = '0, y_in = '0, z_in = '0;
   logic        res_vld;
   logic [63:0] fn_out, aux_out, sig0_out, sig1_out;

   int   total = 0;
   int   bad = 0;
   exp_t q [$];
   exp_t last_e;
   int   b_mode = 0;
   int   b_rnd = 0;
   logic [63:0] seed = 64'h0123_4567_89ab_cdef;

   always #(CLK_P/2) clk = ~clk;

   hash_logic_pool u_hash_logic_pool (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode), .step(step),
      .x_in(x_in), .y_in(y_in), .z_in(z_in), .res_vld(res_vld),
      .fn_out(fn_out), .aux_out(aux_out), .sig0_out(sig0_out), .sig1_out(sig1_out)
   );

   function automatic logic [31:0] r32(input logic [31:0] a, input int n);
      return (a >> n) | (a << (32 - n));
   endfunction

   function automatic logic [63:0] r64(input logic [63:0] a, input int n);
      return (a >> n) | (a << (64 - n));
   endfunction

   function automatic int rounds_of(input int m);
      return (m == 1 || m == 3) ? 80 : 64;
   endfunction

   function automatic exp_t model(input int m, input int rnd,
                                  input logic [63:0] x, input logic [63:0] y, input logic [63:0] z);
      exp_t e;
      logic [63:0] mk, a, b, c, ch, par, maj, zs, yx;
      mk  = (m == 3) ? {64{1'b1}} : 64'h0000_0000_ffff_ffff;
      a = x & mk; b = y & mk; c = z & mk;
      ch  = ((a & b) ^ (~a & c)) & mk;
      par = (a ^ b ^ c) & mk;
      maj = ((a & b) ^ (a & c) ^ (b & c)) & mk;
      zs  = ((a & c) | (b & ~c)) & mk;
      yx  = (b ^ (a | ~c)) & mk;
      e.aux = '0; e.s0 = '0; e.s1 = '0;
      case (m)
         0: begin
            e.rq = "R4/R9/R10";
            case (rnd / 16)
               0: e.fn = ch;
               1: e.fn = zs;
               2: e.fn = par;
               default: e.fn = yx;
            endcase
         end
         1: begin
            e.rq = "R5/R9/R10";
            case (rnd / 20)
               0: e.fn = ch;
               2: e.fn = maj;
               default: e.fn = par;
            endcase
         end
         2: begin
            e.rq = "R6/R7/R9";
            e.fn = ch; e.aux = maj;
            e.s0 = {32'h0, r32(x[31:0], 2) ^ r32(x[31:0], 13) ^ r32(x[31:0], 22)};
            e.s1 = {32'h0, r32(x[31:0], 6) ^ r32(x[31:0], 11) ^ r32(x[31:0], 25)};
         end
         default: begin
            e.rq = "R6/R8";
            e.fn = ch; e.aux = maj;
            e.s0 = r64(x, 28) ^ r64(x, 34) ^ r64(x, 39);
            e.s1 = r64(x, 14) ^ r64(x, 18) ^ r64(x, 41);
         end
      endcase
      return e;
   endfunction

   task automatic check_out(input exp_t e, input string why);
      total++;
      if (fn_out !== e.fn || aux_out !== e.aux || sig0_out !== e.s0 || sig1_out !== e.s1) begin
         bad++;
         $display("FAIL %s %s: fn=%h aux=%h s0=%h s1=%h expected fn=%h aux=%h s0=%h s1=%h",
                  e.rq, why, fn_out, aux_out, sig0_out, sig1_out, e.fn, e.aux, e.s0, e.s1);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (res_vld) begin
            if (q.size() == 0) begin
               total++; bad++;
               $display("FAIL R3/R2: res_vld=1 expected 0 (no step pending)");
            end else begin
               last_e = q.pop_front();
               check_out(last_e, "result");
            end
         end else begin
            check_out(last_e, "hold");
         end
      end
   end

   task automatic next_seed();
      seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
   endtask

   task automatic do_step(input logic [63:0] x, input logic [63:0] y, input logic [63:0] z);
      @(negedge clk);
      q.push_back(model(b_mode, b_rnd, x, y, z));
      b_rnd = (b_rnd == rounds_of(b_mode) - 1) ? 0 : b_rnd + 1;
      cfg_wr = 1'b0; step = 1'b1; x_in = x; y_in = y; z_in = z;
   endtask

   task automatic rand_step();
      logic [63:0] a, b, c;
      next_seed(); a = seed;
      next_seed(); b = seed;
      next_seed(); c = seed;
      do_step(a, b, c);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         step = 1'b0; cfg_wr = 1'b0;
      end
   endtask

   task automatic cfg(input int m, input logic with_step);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_mode = m[1:0]; step = with_step;
      b_mode = m; b_rnd = 0;
      @(negedge clk);
      cfg_wr = 1'b0; step = 1'b0;
   endtask

   initial begin
      #(CLK_P * 150000);
      bad++; total++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      last_e = '{fn: '0, aux: '0, s0: '0, s1: '0, rq: "R1"};
      // R1: reset state
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         total++;
         if (res_vld !== 1'b0 || fn_out !== '0 || aux_out !== '0 || sig0_out !== '0 || sig1_out !== '0) begin
            bad++;
            $display("FAIL R1: vld=%b fn=%h aux=%h expected all zero", res_vld, fn_out, aux_out);
         end
      end
      rst_n = 1'b1;
      idle(2);
      // R1: default mode MD5, round 0, upper input bits ignored (R9)
      for (int i = 0; i < 4; i++) rand_step();
      idle(3);
      // R4: full MD5 schedule plus wrap
      cfg(0, 1'b0);
      for (int i = 0; i < 66; i++) rand_step();
      idle(2);
      // R5: SHA-1 schedule plus wrap
      cfg(1, 1'b0);
      for (int i = 0; i < 82; i++) rand_step();
      idle(2);
      // R6/R7: SHA-256 plus wrap
      cfg(2, 1'b0);
      for (int i = 0; i < 65; i++) rand_step();
      do_step('1, '0, '1);
      do_step(64'h8000_0001_8000_0001, 64'hffff_0000_ffff_0000, 64'h0f0f_0f0f_0f0f_0f0f);
      idle(2);
      // R6/R8: SHA-512 plus wrap, full-width patterns
      cfg(3, 1'b0);
      for (int i = 0; i < 81; i++) rand_step();
      do_step('1, '1, '0);
      do_step(64'h8000_0000_0000_0001, 64'haaaa_aaaa_aaaa_aaaa, 64'h5555_5555_5555_5555);
      idle(3);
      // R2: step colliding with cfg write is dropped, round restarts at 0
      cfg(1, 1'b0);
      for (int i = 0; i < 25; i++) rand_step();
      cfg(1, 1'b1);
      idle(2);
      rand_step();
      rand_step();
      idle(2);
      // R2: mode switch mid-run restarts the MD5 schedule
      cfg(0, 1'b0);
      for (int i = 0; i < 20; i++) rand_step();
      cfg(0, 1'b1);
      rand_step();
      idle(4);
      total++;
      if (q.size() != 0) begin
         bad++;
         $display("FAIL R3: %0d results missing, expected 0", q.size());
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule